// File: doc/BRIEF.md
# Address-Masked GPIO Register Controller

This block is a register-mapped controller for eight general-purpose pins on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to set each pin's direction, drive output levels and read input levels. It also configures per-pin interrupt detection and services the resulting status. A single combined interrupt line goes to the system interrupt controller.

The data register appears across the whole first kilobyte of the address space. Address bits [9:2] act as a per-bit mask, so one access can read or update any subset of pins without a read-modify-write sequence. Input pins pass through a two-flop synchronizer before they reach the data register. A separate detect unit watches the synchronized data for edges or levels and raises raw status bits. Software clears those bits by writing ones to a clear location. Eight fixed identification bytes sit at the top of the 4 KB window.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset every register is zero: pin_oe is 0, pin_out is 0, irq is 0, and the direction, raw status and masked status reads return 0.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2], zero-extended to 32 bits.
- R3: A write at an offset below 0x400 changes only those data bits that are set in both address bits [9:2] and the direction register. Output pins drive the data register on pin_out, and input-pin data bits are not affected by the write.
- R4: The configuration registers keep only the low 8 bits of a write and read back at these offsets: direction 0x400, sense 0x404, both-edges 0x408, event polarity 0x40C, enable 0x410 and alternate select 0x420. pin_oe equals the direction register, where 1 means output, and alt_sel equals the alternate select register.
- R5: A data bit whose direction is input follows pin_in through a two-flop synchronizer and can be read through the data window.
- R6: Edge detection applies to a pin whose sense bit is 0 and which is an input. When a synchronized input changes and its both-edges bit is 1, the raw status bit is set. When its both-edges bit is 0, the bit is set only if the new level equals the event polarity bit (1 means rising, 0 means falling). Changes on output pins never set status.
- R7: With the sense bit at 1, the raw status bit is set on every cycle in which the data bit equals its event polarity bit. A clear issued while that condition holds leaves the bit set.
- R8: A write to 0x41C clears each raw status bit whose written data bit is 1. Reads of 0x41C return 0.
- R9: Offset 0x414 reads the raw status and 0x418 reads the raw status ANDed with the enable register. irq is 1 exactly when that masked value is nonzero.
- R10: Offset 0xFE0 + 4n (n = 0..7) reads byte n of the sequence 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R11: Reads of reserved offsets (0x424 to 0xFDC) return 0. A write to a reserved or read-only offset (0x414, 0x418, 0xFE0 to 0xFFC, 0x424 to 0xFDC) changes no state, and it raises wr_err for exactly the one cycle after the write. Valid writes leave wr_err low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| wr_err | output | 1 | One-cycle pulse after an ignored write |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Pin output levels (data register) |
| pin_oe | output | 8 | Pin output enables (direction register) |
| alt_sel | output | 8 | Stored alternate-function select |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a level-sensitive status bit that is cleared on the same edge where its condition still holds. Only the clear-versus-set priority decides whether the bit survives. To reach it, the stimulus first configures a pin as level-sensitive and holds that pin at the active level through the synchronizer. It then issues the clear and reads raw status to confirm the bit survived. Finally it drops the pin and clears again to show the bit now goes away. Edge cases are reached in the same way, by stepping pin_in one bit at a time and waiting out the synchronizer latency. This separates rising, falling and both-edge behaviour per pin.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVT,
        SEL_ENA,
        SEL_RAW,
        SEL_MIS,
        SEL_CLR,
        SEL_ALT,
        SEL_ID,
        SEL_RSVD
    } reg_sel_e;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] sense;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] evt;
        logic [NPINS-1:0] ena;
        logic [NPINS-1:0] alt;
    } cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a < 12'h400) begin
            s = SEL_DATA;
        end else if (a >= 12'hFE0) begin
            s = SEL_ID;
        end else begin
            case (a[ADDR_W-1:2])
                10'h100: s = SEL_DIR;
                10'h101: s = SEL_SENSE;
                10'h102: s = SEL_BOTH;
                10'h103: s = SEL_EVT;
                10'h104: s = SEL_ENA;
                10'h105: s = SEL_RAW;
                10'h106: s = SEL_MIS;
                10'h107: s = SEL_CLR;
                10'h108: s = SEL_ALT;
                default: s = SEL_RSVD;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: b = 8'h61;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    function automatic logic sel_writable(input reg_sel_e s);
        return (s == SEL_DATA) || (s == SEL_DIR) || (s == SEL_SENSE) ||
               (s == SEL_BOTH) || (s == SEL_EVT) || (s == SEL_ENA) ||
               (s == SEL_CLR)  || (s == SEL_ALT);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] sense,
    input  logic [WIDTH-1:0] both,
    input  logic [WIDTH-1:0] evt,
    output logic [WIDTH-1:0] set_vec
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] changed;
    logic [WIDTH-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    assign changed = (cur ^ prev_q) & ~dir;
    assign match   = ~(cur ^ evt);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            always_comb begin
                if (sense[i]) begin
                    set_vec[i] = match[i];
                end else if (changed[i]) begin
                    set_vec[i] = both[i] | match[i];
                end else begin
                    set_vec[i] = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
    import gpio_mask_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_err,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  alt_sel,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NPINS;

    reg_sel_e         sel;
    cfg_t             cfg_q;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] raw_q;
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] byte_mask;
    logic [NPINS-1:0] wr_mask;
    logic [NPINS-1:0] clr_bits;
    logic [NPINS-1:0] masked;
    logic             err_q;

    assign sel       = decode_addr(addr);
    assign byte_mask = addr[NPINS+1:2];
    assign wr_mask   = (wr_en && sel == SEL_DATA) ? (byte_mask & cfg_q.dir) : '0;
    assign clr_bits  = (wr_en && sel == SEL_CLR) ? wdata[NPINS-1:0] : '0;
    assign masked    = raw_q & cfg_q.ena;

    gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (sync_in)
    );

    gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .cur     (data_q),
        .dir     (cfg_q.dir),
        .sense   (cfg_q.sense),
        .both    (cfg_q.both),
        .evt     (cfg_q.evt),
        .set_vec (set_vec)
    );

    // Data register: inputs follow the synchronizer, outputs take masked writes.
    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst)               data_q[i] <= 1'b0;
                else if (!cfg_q.dir[i]) data_q[i] <= sync_in[i];
                else if (wr_mask[i])   data_q[i] <= wdata[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:   cfg_q.dir   <= wdata[NPINS-1:0];
                SEL_SENSE: cfg_q.sense <= wdata[NPINS-1:0];
                SEL_BOTH:  cfg_q.both  <= wdata[NPINS-1:0];
                SEL_EVT:   cfg_q.evt   <= wdata[NPINS-1:0];
                SEL_ENA:   cfg_q.ena   <= wdata[NPINS-1:0];
                SEL_ALT:   cfg_q.alt   <= wdata[NPINS-1:0];
                default:   ;
            endcase
        end
    end

    // Set has priority over clear so a held level re-asserts at once.
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_bits) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= wr_en && !sel_writable(sel);
    end

    always_comb begin
        logic [NPINS-1:0] v;
        case (sel)
            SEL_DATA:  v = data_q & byte_mask;
            SEL_DIR:   v = cfg_q.dir;
            SEL_SENSE: v = cfg_q.sense;
            SEL_BOTH:  v = cfg_q.both;
            SEL_EVT:   v = cfg_q.evt;
            SEL_ENA:   v = cfg_q.ena;
            SEL_RAW:   v = raw_q;
            SEL_MIS:   v = masked;
            SEL_ALT:   v = cfg_q.alt;
            SEL_ID:    v = id_byte(addr[4:2]);
            default:   v = '0;
        endcase
        rdata = {{PAD_W{1'b0}}, v};
    end

    assign pin_out = data_q;
    assign pin_oe  = cfg_q.dir;
    assign alt_sel = cfg_q.alt;
    assign irq     = |masked;
    assign wr_err  = err_q;
endmodule

// File: rtl/gpio_mask_ctrl_chk.sv
module gpio_mask_ctrl_chk
    import gpio_mask_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              wr_err,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  ena,
    input logic              irq
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && irq == 1'b0 && pin_out == '0));

    a_r2_read_masked: assert property (@(posedge clk) disable iff (rst)
        (addr < 12'h400) |-> ((rdata & ~{24'b0, addr[9:2]}) == '0));

    a_r3_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (((pin_out ^ $past(pin_out)) & $past(pin_oe) & pin_oe) == '0));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ena != '0));

    a_r10_id_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (addr >= 12'hFE0) |-> (rdata[31:8] == '0));

    a_r11_err_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));

    a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> (!wr_err || $past(wr_en)));
endmodule

bind gpio_mask_ctrl gpio_mask_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rdata   (rdata),
    .wr_err  (wr_err),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .ena     (cfg_q.ena),
    .irq     (irq)
);

// File: tb/gpio_mask_ctrl_test.sv
module gpio_mask_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wr_err;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, alt_sel;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    typedef enum int {K_RD, K_OUT, K_OE, K_IRQ, K_ERR, K_ALT} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_mask_ctrl uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .wr_err(wr_err), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
    );

    // Monitor: compares queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_OUT:   act = {24'b0, pin_out};
                K_OE:    act = {24'b0, pin_oe};
                K_IRQ:   act = {31'b0, irq};
                K_ERR:   act = {31'b0, wr_err};
                default: act = {24'b0, alt_sel};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.kind = K_RD; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_out(input kind_e k, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(12'h400, 32'h0, "R1 dir reset");
        expect_out(K_OE, 32'h0, "R1 pin_oe reset");
        expect_out(K_IRQ, 32'h0, "R1 irq reset");
        expect_out(K_OUT, 32'h0, "R1 pin_out reset");
        rd(12'h414, 32'h0, "R1 raw reset");
        rd(12'h418, 32'h0, "R1 masked reset");

        // R4 direction keeps low byte
        wr(12'h400, 32'h0001_FF0F);
        rd(12'h400, 32'h0F, "R4 dir readback");
        expect_out(K_OE, 32'h0F, "R4 pin_oe follows dir");

        // R3 masked writes
        wr(12'h3FC, 32'hFF);
        expect_out(K_OUT, 32'h0F, "R3 only output bits written");
        wr(12'h014, 32'h00);
        expect_out(K_OUT, 32'h0A, "R3 mask 0x05 clears bits 0,2");
        // R2 masked reads
        rd(12'h3FC, 32'h0A, "R2 full mask read");
        rd(12'h008, 32'h02, "R2 mask bit1 read");
        rd(12'h004, 32'h00, "R2 mask bit0 read");

        // R5 inputs through synchronizer
        pin_in = 8'hA0;
        settle();
        rd(12'h3FC, 32'hAA, "R5 inputs visible");
        rd(12'h200, 32'h80, "R5 single input via mask");
        wr(12'h3FC, 32'h00);
        rd(12'h3FC, 32'hA0, "R3 input bits untouched by write");
        rd(12'h414, 32'h00, "R6 rising ignored when event=0");

        // R6 falling edge with event 0
        pin_in = 8'h20;
        settle();
        rd(12'h414, 32'h80, "R6 falling edge sets raw");
        rd(12'h418, 32'h00, "R9 masked zero with enable off");
        expect_out(K_IRQ, 32'h0, "R9 irq low with enable off");

        // R9 enable
        wr(12'h410, 32'hFFFF_FFFF);
        rd(12'h410, 32'hFF, "R4 enable readback");
        rd(12'h418, 32'h80, "R9 masked status");
        expect_out(K_IRQ, 32'h1, "R9 irq high");

        // R8 clear
        wr(12'h41C, 32'h80);
        rd(12'h414, 32'h00, "R8 clear raw");
        expect_out(K_IRQ, 32'h0, "R8 irq drops after clear");
        rd(12'h41C, 32'h00, "R8 clear reads zero");

        // R6 both edges on bit 6
        wr(12'h408, 32'h40);
        rd(12'h408, 32'h40, "R4 both readback");
        pin_in = 8'h60;
        settle();
        rd(12'h414, 32'h40, "R6 both-edge rising");
        wr(12'h41C, 32'hFF);
        pin_in = 8'h20;
        settle();
        rd(12'h414, 32'h40, "R6 both-edge falling");
        wr(12'h41C, 32'hFF);

        // R6 rising detect on bit 4
        wr(12'h40C, 32'h10);
        rd(12'h40C, 32'h10, "R4 event readback");
        pin_in = 8'h30;
        settle();
        rd(12'h414, 32'h10, "R6 rising edge sets raw");
        wr(12'h41C, 32'hFF);
        pin_in = 8'h20;
        settle();
        rd(12'h414, 32'h00, "R6 falling ignored when event=1");

        // R6 output pins never set status
        wr(12'h004, 32'h01);
        wr(12'h004, 32'h00);
        settle();
        rd(12'h414, 32'h00, "R6 output toggles ignored");

        // R7 level detect on bit 5, active high
        wr(12'h40C, 32'h30);
        wr(12'h404, 32'hFFFF_FF20);
        rd(12'h404, 32'h20, "R4 sense readback");
        settle();
        rd(12'h414, 32'h20, "R7 level sets raw");
        wr(12'h41C, 32'h20);
        rd(12'h414, 32'h20, "R7 level survives clear");
        expect_out(K_IRQ, 32'h1, "R7 irq held by level");
        pin_in = 8'h00;
        settle();
        wr(12'h41C, 32'h20);
        rd(12'h414, 32'h00, "R7 clear after level drops");
        expect_out(K_IRQ, 32'h0, "R7 irq low after level drops");

        // R4 alternate select
        wr(12'h420, 32'h1A5);
        rd(12'h420, 32'hA5, "R4 alt readback");
        expect_out(K_ALT, 32'hA5, "R4 alt_sel output");

        // R10 identification
        rd(12'hFE0, 32'h61, "R10 id0");
        rd(12'hFE4, 32'h10, "R10 id1");
        rd(12'hFEC, 32'h00, "R10 id3");
        rd(12'hFF4, 32'hF0, "R10 id5");
        rd(12'hFF8, 32'h05, "R10 id6");
        rd(12'hFFC, 32'hB1, "R10 id7");

        // R11 reserved / read-only
        rd(12'h500, 32'h0, "R11 reserved reads zero");
        wr(12'h500, 32'hFFFF_FFFF);
        expect_out(K_ERR, 32'h1, "R11 err on reserved write");
        @(posedge clk); #1;
        expect_out(K_ERR, 32'h0, "R11 err lasts one cycle");
        wr(12'h414, 32'hFF);
        expect_out(K_ERR, 32'h1, "R11 err on raw-status write");
        rd(12'h414, 32'h00, "R11 raw unchanged by write");
        wr(12'hFE0, 32'h00);
        expect_out(K_ERR, 32'h1, "R11 err on id write");
        rd(12'hFE0, 32'h61, "R11 id unchanged");
        wr(12'h400, 32'h0F);
        expect_out(K_ERR, 32'h0, "R11 no err on valid write");
        rd(12'h400, 32'h0F, "R11 dir unchanged by bad writes");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule